// File: doc/BRIEF.md
# Character LCD Write Sequencer

This block drives a two-row, sixteen-column parallel character display over an 8-bit bus. It only ever writes: every byte, whether a command or a character, reaches the display as a three-step transfer. First enable goes high. Then the register-select level and the byte appear on the bus. Finally enable drops, and the display captures the byte on that falling edge. Each step is held for a fixed time, nominally one millisecond. This is far longer than any display timing minimum, so no busy-flag polling is needed.

After reset the block sets up the display and writes two fixed messages without outside help. It clears the display, selects cursor-moves-right entry mode and writes the first-row text. It then moves the cursor to the start of the second row and writes the second-row text. Both texts are parameters. Once this start-up run is over, the block accepts further command or character bytes from a valid/ready request port, one transfer at a time.

Top module: `lcd_write_seq`

## Requirements
- R1: While `rst_ni` is low, `lcd_o` is all zeros and `req_ready_o` is low.
- R2: After reset is released, the first two transfers are the clear command (byte 0x01, register select low), then the entry-mode command (byte 0x06, register select low).
- R3: The first-row text follows the entry-mode command. It is sent one character at a time, as ASCII codes with register select high, starting with the first character of the text.
- R4: The cursor-to-second-row command follows the first-row text. It is byte 0xC0 (0x80 OR address 0x40) with register select low. The second-row text follows it, sent the same way as in R3.
- R5: At most 16 characters are sent for each row. Characters of a row text beyond the sixteenth are never sent.
- R6: In each transfer, enable rises while register select and data keep their previous values. The new register select and data appear one step later, with enable still high. Enable falls one step after that, with register select and data unchanged. The byte the display latches is the one on the bus at that falling edge.
- R7: A step lasts exactly STEP_CYCLES clock cycles, so enable stays high for 2*STEP_CYCLES cycles. After enable falls it stays low for at least STEP_CYCLES cycles before the next transfer.
- R8: Read/write (`lcd_o[8]`) is always low.
- R9: `req_ready_o` is high only after the start-up run has finished and while no transfer is in progress. A request held valid while the block is busy is accepted only once ready is high. An accepted request produces exactly one transfer, with register select equal to `req_rs_i` (1 = character, 0 = command) and data equal to `req_data_i`.
- R10: `lcd_o` is laid out as bit 10 = enable, bit 9 = register select, bit 8 = read/write, and bits 7..0 = display data D7..D0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request byte is offered |
| req_rs_i | input | 1 | Register select for the request: 1 = character, 0 = command |
| req_data_i | input | 8 | Byte to write |
| req_ready_o | output | 1 | The request is accepted in a cycle where valid and ready are both high |
| lcd_o | output | 11 | Display lines: {enable, register select, read/write, D7..D0} |

## Verification
The bench checks the start-up order byte by byte. A sequencer that skipped the clear, sent the row jump with register select high, or used the wrong row address would pop a mismatching byte. The second-row text is longer than sixteen characters, and the line after its sixteenth character must be the first external request. A design that ignored the row cap would send extra characters into the scoreboard. A monitor times every edge of enable against the step length, and checks that register select and data hold still at both enable edges. This catches a design that sets up the byte together with the rising edge, or changes it at the falling edge. Requests are held valid during the start-up run and sent back to back, including the same character twice. A design that accepted while busy would drop or reorder bytes.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int unsigned LCD_COLS = 16;
  localparam logic [7:0] CMD_CLEAR     = 8'h01;
  localparam logic [7:0] CMD_ENTRY_INC = 8'h06;
  localparam logic [7:0] CMD_SET_DDRAM = 8'h80;
  localparam logic [6:0] ROW2_ADDR     = 7'h40;

  typedef struct packed {
    logic       rs;
    logic [7:0] data;
  } lcd_byte_t;

  typedef struct packed {
    logic       en;
    logic       rs;
    logic       rw;
    logic [7:0] data;
  } lcd_bus_t;

  typedef enum logic [1:0] {X_IDLE, X_RISE, X_SETUP, X_FALL} xfer_st_e;
  typedef enum logic [2:0] {I_CLEAR, I_ENTRY, I_ROW0, I_JUMP, I_ROW1, I_RUN} init_st_e;
endpackage

// File: rtl/lcd_step_timer.sv
module lcd_step_timer #(
  parameter int unsigned STEP_CYCLES = 50000,
  localparam int unsigned CW = $clog2(STEP_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == CW'(STEP_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lcd_xfer_engine.sv
module lcd_xfer_engine
  import lcd_seq_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 50000
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  lcd_byte_t byte_i,
  output logic      idle_o,
  output lcd_bus_t  bus_o
);
  xfer_st_e  st_q;
  lcd_byte_t pend_q;
  lcd_bus_t  bus_q;
  logic      step_done;

  lcd_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (st_q != X_IDLE),
    .expire_o(step_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= X_IDLE;
      pend_q <= '0;
      bus_q  <= '0;
    end else begin
      unique case (st_q)
        X_IDLE: if (start_i) begin
          st_q     <= X_RISE;
          pend_q   <= byte_i;
          bus_q.en <= 1'b1;   // enable first, bus still old
        end
        X_RISE: if (step_done) begin
          st_q       <= X_SETUP;
          bus_q.rs   <= pend_q.rs;
          bus_q.data <= pend_q.data;
        end
        X_SETUP: if (step_done) begin
          st_q     <= X_FALL;
          bus_q.en <= 1'b0;   // display latches here
        end
        X_FALL: if (step_done) st_q <= X_IDLE;
        default: st_q <= X_IDLE;
      endcase
    end
  end

  assign idle_o = (st_q == X_IDLE);
  assign bus_o  = bus_q;

  AST_START_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> st_q == X_IDLE); // R9
  AST_RISE_BUS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_q.en) |-> $stable({bus_q.rs, bus_q.data})); // R6
  AST_FALL_BUS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_q.en) |-> $stable({bus_q.rs, bus_q.data})); // R6
  AST_SETUP_MATCHES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == X_SETUP) |-> ({bus_q.rs, bus_q.data} == pend_q && bus_q.en)); // R6
  AST_IDLE_EN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == X_IDLE) |-> !bus_q.en); // R7
endmodule

// File: rtl/lcd_row_text.sv
module lcd_row_text
  import lcd_seq_pkg::*;
#(
  parameter int unsigned MAX_CHARS = 20,
  parameter int unsigned TEXT_LEN  = 0,
  parameter logic [8*MAX_CHARS-1:0] TEXT = '0,
  localparam int unsigned IW = $clog2(LCD_COLS + 1),
  localparam int unsigned AW = $clog2(LCD_COLS),
  localparam int unsigned LIM = (MAX_CHARS < LCD_COLS) ? MAX_CHARS : LCD_COLS,
  localparam int unsigned SHOWN = (TEXT_LEN < LIM) ? TEXT_LEN : LIM
) (
  input  logic [IW-1:0] idx_i,
  output logic [7:0]    char_o,
  output logic [IW-1:0] count_o
);
  logic [7:0] chars [LCD_COLS];

  // first character sits in the top byte of TEXT
  for (genvar g = 0; g < LCD_COLS; g++) begin : g_col
    if (g < MAX_CHARS) begin : g_txt
      assign chars[g] = TEXT[8*(MAX_CHARS-1-g) +: 8];
    end else begin : g_pad
      assign chars[g] = 8'h20;
    end
  end

  assign char_o  = (idx_i < IW'(LCD_COLS)) ? chars[idx_i[AW-1:0]] : 8'h20;
  assign count_o = IW'(SHOWN);
endmodule

// File: rtl/lcd_init_ctrl.sv
module lcd_init_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int unsigned MAX_CHARS = 20,
  parameter int unsigned ROW0_LEN  = 0,
  parameter logic [8*MAX_CHARS-1:0] ROW0_TEXT = '0,
  parameter int unsigned ROW1_LEN  = 0,
  parameter logic [8*MAX_CHARS-1:0] ROW1_TEXT = '0,
  localparam int unsigned IW = $clog2(LCD_COLS + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      eng_idle_i,
  output logic      issue_o,
  output lcd_byte_t byte_o,
  output logic      run_o
);
  init_st_e      st_q;
  logic [IW-1:0] idx_q;
  logic [7:0]    ch0, ch1;
  logic [IW-1:0] cnt0, cnt1;

  lcd_row_text #(.MAX_CHARS(MAX_CHARS), .TEXT_LEN(ROW0_LEN), .TEXT(ROW0_TEXT)) u_row0 (
    .idx_i(idx_q), .char_o(ch0), .count_o(cnt0));
  lcd_row_text #(.MAX_CHARS(MAX_CHARS), .TEXT_LEN(ROW1_LEN), .TEXT(ROW1_TEXT)) u_row1 (
    .idx_i(idx_q), .char_o(ch1), .count_o(cnt1));

  always_comb begin
    issue_o = 1'b0;
    byte_o  = '0;
    unique case (st_q)
      I_CLEAR: begin issue_o = eng_idle_i; byte_o = '{rs: 1'b0, data: CMD_CLEAR}; end
      I_ENTRY: begin issue_o = eng_idle_i; byte_o = '{rs: 1'b0, data: CMD_ENTRY_INC}; end
      I_ROW0: begin
        issue_o = eng_idle_i && (idx_q < cnt0);
        byte_o  = '{rs: 1'b1, data: ch0};
      end
      I_JUMP: begin
        issue_o = eng_idle_i;
        byte_o  = '{rs: 1'b0, data: CMD_SET_DDRAM | {1'b0, ROW2_ADDR}};
      end
      I_ROW1: begin
        issue_o = eng_idle_i && (idx_q < cnt1);
        byte_o  = '{rs: 1'b1, data: ch1};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= I_CLEAR;
      idx_q <= '0;
    end else begin
      unique case (st_q)
        I_CLEAR: if (issue_o) st_q <= I_ENTRY;
        I_ENTRY: if (issue_o) begin st_q <= I_ROW0; idx_q <= '0; end
        I_ROW0:
          if (idx_q >= cnt0)  st_q <= I_JUMP;
          else if (issue_o)   idx_q <= idx_q + 1'b1;
        I_JUMP:  if (issue_o) begin st_q <= I_ROW1; idx_q <= '0; end
        I_ROW1:
          if (idx_q >= cnt1)  st_q <= I_RUN;
          else if (issue_o)   idx_q <= idx_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign run_o = (st_q == I_RUN);

  AST_ROW_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && byte_o.rs) |-> idx_q < IW'(LCD_COLS)); // R5
  AST_ENTRY_AFTER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == I_ENTRY) |-> ($past(st_q) == I_CLEAR || $past(st_q) == I_ENTRY)); // R2
  AST_ROW1_AFTER_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == I_ROW1 && $past(st_q) != I_ROW1) |-> $past(st_q) == I_JUMP); // R4
  AST_ISSUE_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> eng_idle_i); // R9
endmodule

// File: rtl/lcd_write_seq.sv
module lcd_write_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned STEP_CYCLES = CLK_HZ / 1000,
  parameter int unsigned MAX_CHARS   = 20,
  parameter int unsigned ROW0_LEN    = 11,
  parameter logic [8*MAX_CHARS-1:0] ROW0_TEXT = {"HELLO WORLD", {9{8'h20}}},
  parameter int unsigned ROW1_LEN    = 14,
  parameter logic [8*MAX_CHARS-1:0] ROW1_TEXT = {"CHAR LCD READY", {6{8'h20}}}
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_rs_i,
  input  logic [7:0]  req_data_i,
  output logic        req_ready_o,
  output logic [10:0] lcd_o
);
  logic      eng_idle, init_issue, run, start;
  lcd_byte_t init_byte, sel_byte;
  lcd_bus_t  bus;

  lcd_init_ctrl #(
    .MAX_CHARS(MAX_CHARS),
    .ROW0_LEN(ROW0_LEN), .ROW0_TEXT(ROW0_TEXT),
    .ROW1_LEN(ROW1_LEN), .ROW1_TEXT(ROW1_TEXT)
  ) u_init (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eng_idle_i(eng_idle),
    .issue_o   (init_issue),
    .byte_o    (init_byte),
    .run_o     (run)
  );

  assign req_ready_o = run && eng_idle;
  assign start       = run ? (req_valid_i && eng_idle) : init_issue;
  assign sel_byte    = run ? '{rs: req_rs_i, data: req_data_i} : init_byte;

  lcd_xfer_engine #(.STEP_CYCLES(STEP_CYCLES)) u_xfer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .byte_i (sel_byte),
    .idle_o (eng_idle),
    .bus_o  (bus)
  );

  assign lcd_o = bus;

  AST_READY_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !lcd_o[10]); // R9
  AST_ACCEPT_STARTS_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (lcd_o[10] && !req_ready_o)); // R9
endmodule

// File: tb/tb_lcd_write_seq.sv
module tb_lcd_write_seq;
  localparam int unsigned STEP = 4;
  localparam logic [159:0] T0 = {"0A", {18{8'h20}}};
  localparam logic [159:0] T1 = {"ABCDEFGHIJKLMNOPQR", 8'h20, 8'h20};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_rs = 1'b0;
  logic [7:0]  req_data = 8'h00;
  logic        req_ready;
  logic [10:0] lcd;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [8:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  lcd_write_seq #(
    .CLK_HZ(1000), .STEP_CYCLES(STEP), .MAX_CHARS(20),
    .ROW0_LEN(2), .ROW0_TEXT(T0), .ROW1_LEN(18), .ROW1_TEXT(T1)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_rs_i(req_rs),
    .req_data_i(req_data), .req_ready_o(req_ready), .lcd_o(lcd)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic rs, input logic [7:0] d, input string tag);
    exp_q.push_back({rs, d});
    tag_q.push_back(tag);
  endtask

  // driver: hold valid until a cycle with ready high
  task automatic send(input logic rs, input logic [7:0] d, input string tag);
    push_exp(rs, d, tag);
    @(negedge clk);
    req_valid = 1'b1; req_rs = rs; req_data = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R9 ready low after accept", 32'(req_ready), 0);
  endtask

  // monitor
  logic       prev_en = 1'b0;
  logic [8:0] prev_bus = '0;
  int k = 0, chg_k = -1, low_k = 1000;
  bit rw_bad = 1'b0, rdy_bad = 1'b0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (lcd[8] !== 1'b0) rw_bad = 1'b1;
      if (lcd[10] && req_ready) rdy_bad = 1'b1;
      if (!prev_en && lcd[10]) begin
        check(low_k >= int'(STEP), "R7 enable low gap", 32'(low_k), STEP);
        check(lcd[9:0] == {prev_bus[8], 1'b0, prev_bus[7:0]}, "R6 bus held at enable rise",
              32'(lcd[9:0]), 32'({prev_bus[8], 1'b0, prev_bus[7:0]}));
        k = 0; chg_k = -1;
      end else if (lcd[10]) begin
        k++;
        if ({lcd[9], lcd[7:0]} != prev_bus) chg_k = k;
      end else if (prev_en) begin
        k++;
        check(k == int'(2 * STEP), "R7 enable high time", 32'(k), 2 * STEP);
        check({lcd[9], lcd[7:0]} == prev_bus, "R6 bus held at enable fall",
              32'({lcd[9], lcd[7:0]}), 32'(prev_bus));
        if (chg_k >= 0)
          check(chg_k == int'(STEP), "R6 setup one step after rise", 32'(chg_k), STEP);
        if (exp_q.size() == 0) begin
          check(1'b0, "R5/R9 unexpected transfer", 32'({lcd[9], lcd[7:0]}), 0);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({lcd[9], lcd[7:0]} == e, $sformatf("%s R10 latched byte", t),
                32'({lcd[9], lcd[7:0]}), 32'(e));
        end
        low_k = 1;
      end else begin
        low_k++;
      end
      prev_en  = lcd[10];
      prev_bus = {lcd[9], lcd[7:0]};
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(lcd == 11'h000, "R1 bus low in reset", 32'(lcd), 0);
    check(req_ready == 1'b0, "R1 ready low in reset", 32'(req_ready), 0);
    push_exp(1'b0, 8'h01, "R2 clear");
    push_exp(1'b0, 8'h06, "R2 entry mode");
    push_exp(1'b1, 8'h30, "R3 row0 char 0");
    push_exp(1'b1, 8'h41, "R3 row0 char A");
    push_exp(1'b0, 8'hC0, "R4 row jump");
    for (int i = 0; i < 16; i++) push_exp(1'b1, 8'h41 + 8'(i), "R4 R5 row1 char");
    rst_ni = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b0, "R9 not ready during start-up", 32'(req_ready), 0);
    // held valid from the start: must wait for the start-up run
    send(1'b0, 8'h80, "R9 command via port");
    send(1'b1, 8'h5A, "R9 char via port");
    send(1'b1, 8'h5A, "R9 repeated char");
    send(1'b1, 8'h00, "R9 zero byte");
    wait (exp_q.size() == 0);
    repeat (3 * STEP + 4) @(negedge clk);
    check(req_ready == 1'b1, "R9 ready when idle", 32'(req_ready), 1);
    check(exp_q.size() == 0, "R5 no missing transfers", 32'(exp_q.size()), 0);
    check(!rw_bad, "R8 read/write always low", 32'(rw_bad), 0);
    check(!rdy_bad, "R9 ready low during transfer", 32'(rdy_bad), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired, pending=%0d expected=0", exp_q.size());
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule